// File: doc/BRIEF.md
# Four-Lane Packed Multiply-Sum Accumulator

This block is a pipelined arithmetic unit for packed 16-bit signal processing. On each cycle it can accept two packed source words and an accumulator word. Each source word carries four signed 16-bit lanes. In dot mode the unit forms the four pairwise lane products, reduces them through an adder tree and adds the total to the full-width accumulator. No rounding or saturation is applied, so the result is exact up to the 64-bit wrap.

A second mode serves fixed-point filter code. Only the lowest lane pair is used. The product is doubled, clamped to the signed 32-bit range, and then added to the low 32 bits of the accumulator with 32-bit saturation. The answer is returned sign-extended to 64 bits.

The unit is fully pipelined over three register stages: multiply, reduce, accumulate. It takes a new operation every cycle, and `out_valid` marks the cycle in which each answer appears. Operand fetch, result write-back and hazard handling belong to the surrounding datapath.

Top module: `mulsum_acc`

## Requirements
- R1: While `rst_n` is low and after its release, before any operation completes, `out_valid` is 0 and `result` is 0.
- R2: With `in_mode` = 0 (dot mode), `result` equals `acc_in` plus the sum over lanes l = 0..3 of the signed product of `src_a[16l+15:16l]` and `src_b[16l+15:16l]`, each product sign-extended to 64 bits.
- R3: Dot mode applies no rounding or saturation: a sum beyond the signed 64-bit range wraps modulo 2^64. For example, all lanes at -32768 with `acc_in` = 0x7FFF_FFFF_FFFF_FFFF gives 0x8000_0000_FFFF_FFFF.
- R4: An operation presented with `in_valid` = 1 at a rising edge produces `out_valid` = 1 and its `result` after the third rising edge that follows, counting that edge as the first.
- R5: Operations may be issued on consecutive cycles with no gap, and each result appears in issue order, one per cycle.
- R6: With `in_mode` = 1 (fixed mode), the signed product of lane 0 is doubled and clamped to [-2^31, 2^31-1]. For example, -32768 times -32768 yields 0x7FFF_FFFF.
- R7: In fixed mode the clamped product is added to the signed value of `acc_in[31:0]`, and the sum is clamped to [-2^31, 2^31-1]. `result` is that value sign-extended to 64 bits, and `acc_in[63:32]` has no effect.
- R8: In fixed mode, lanes 1 to 3 of both sources have no effect on `result`.
- R9: A cycle with `in_valid` = 0 produces `out_valid` = 0 three cycles later, and `result` keeps its previous value in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_mode | input | 1 | 0 = four-lane dot product, 1 = lane-0 fixed-point with saturation |
| src_a | input | 64 | First packed source, four signed 16-bit lanes, lane 0 in the low bits |
| src_b | input | 64 | Second packed source, same layout |
| acc_in | input | 64 | Accumulator operand |
| out_valid | output | 1 | Result present |
| result | output | 64 | Accumulated result |

## Verification
Every answer is due three rising edges after the edge that samples its inputs, and this holds in both modes. The bench drives inputs on falling edges and keeps a three-deep queue of expected outcomes. On each falling edge it compares the outputs against the entry pushed three falling edges earlier. That entry may be a valid result that must match the arithmetic model, or a bubble, for which `out_valid` must be low and `result` must hold its previous value. Because of this, any early, late or dropped result is caught in the exact cycle, whether operations are issued back to back or with bubbles between them.

// File: rtl/mulsum_pkg.sv
package mulsum_pkg;

   typedef enum logic {
      MODE_DOT = 1'b0,
      MODE_FIX = 1'b1
   } ms_mode_e;

endpackage

// File: rtl/ms_lane_mul.sv
module ms_lane_mul #(
   parameter int LANE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [LANE_W-1:0]     a,
   input  logic [LANE_W-1:0]     b,
   output logic [2*LANE_W-1:0]   prod
);
   localparam int PROD_W = 2 * LANE_W;
   localparam logic signed [PROD_W-1:0] P_HI = PROD_W'(1) <<< (PROD_W - 2);
   localparam logic signed [PROD_W-1:0] P_LO = -P_HI + (PROD_W'(1) <<< (LANE_W - 1));

   if (LANE_W < 2) begin : g_bad_width
      $error("ms_lane_mul: LANE_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod <= '0;
      end else if (en) begin
         prod <= PROD_W'($signed(a) * $signed(b));
      end
   end

   // R2
   prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($signed(prod) <= P_HI) && ($signed(prod) >= P_LO));

endmodule

// File: rtl/ms_reduce.sv
module ms_reduce
   import mulsum_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int PROD_W = 32,
   parameter int ACC_W  = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     v_in,
   input  ms_mode_e                 mode_in,
   input  logic [ACC_W-1:0]         acc_in,
   input  logic [LANES*PROD_W-1:0]  prod_flat,
   output logic                     v_out,
   output ms_mode_e                 mode_out,
   output logic [ACC_W-1:0]         acc_out,
   output logic [ACC_W-1:0]         sum_out
);
   localparam logic signed [PROD_W-1:0] FIX_MAX = {1'b0, {(PROD_W-1){1'b1}}};
   localparam logic signed [PROD_W-1:0] FIX_MIN = {1'b1, {(PROD_W-1){1'b0}}};
   localparam logic signed [PROD_W-1:0] SQ_MAX  = PROD_W'(1) <<< (PROD_W - 2);
   localparam logic signed [ACC_W-1:0]  TREE_MAX = ACC_W'(LANES) <<< (PROD_W - 2);

   if (ACC_W <= PROD_W) begin : g_bad_acc
      $error("ms_reduce: ACC_W must exceed PROD_W");
   end

   logic signed [ACC_W-1:0]  tree_sum;
   logic signed [PROD_W:0]   dbl;
   logic signed [PROD_W-1:0] fix_val;
   logic                     dbl_ovf;

   // Balanced adder tree, halving the operand count at each level
   always_comb begin
      logic signed [ACC_W-1:0] t [LANES];
      for (int l = 0; l < LANES; l++) begin
         t[l] = ACC_W'($signed(prod_flat[l*PROD_W +: PROD_W]));
      end
      for (int w = LANES / 2; w >= 1; w = w / 2) begin
         for (int i = 0; i < w; i++) begin
            t[i] = t[2*i] + t[2*i+1];
         end
      end
      tree_sum = t[0];
   end

   // Lane-0 product doubled, clamped to the product width
   always_comb begin
      dbl     = {prod_flat[PROD_W-1:0], 1'b0};
      dbl_ovf = dbl[PROD_W] != dbl[PROD_W-1];
      if (dbl_ovf) begin
         fix_val = dbl[PROD_W] ? FIX_MIN : FIX_MAX;
      end else begin
         fix_val = dbl[PROD_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out    <= 1'b0;
         mode_out <= MODE_DOT;
         acc_out  <= '0;
         sum_out  <= '0;
      end else begin
         v_out <= v_in;
         if (v_in) begin
            mode_out <= mode_in;
            acc_out  <= acc_in;
            sum_out  <= (mode_in == MODE_FIX) ? ACC_W'(fix_val) : tree_sum;
         end
      end
   end

   // R6
   fix_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && mode_in == MODE_FIX && $signed(prod_flat[PROD_W-1:0]) == SQ_MAX)
      |=> (sum_out == ACC_W'(FIX_MAX)));

   // R2
   tree_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_out && mode_out == MODE_DOT)
      |-> ($signed(sum_out) <= TREE_MAX) && ($signed(sum_out) >= -TREE_MAX));

endmodule

// File: rtl/ms_accum.sv
module ms_accum
   import mulsum_pkg::*;
#(
   parameter int ACC_W = 64,
   parameter int FIX_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_in,
   input  ms_mode_e          mode_in,
   input  logic [ACC_W-1:0]  acc_in,
   input  logic [ACC_W-1:0]  sum_in,
   output logic              v_out,
   output logic [ACC_W-1:0]  result
);
   localparam logic signed [FIX_W-1:0] F_MAX = {1'b0, {(FIX_W-1){1'b1}}};
   localparam logic signed [FIX_W-1:0] F_MIN = {1'b1, {(FIX_W-1){1'b0}}};

   if (FIX_W >= ACC_W || FIX_W < 2) begin : g_bad_fix
      $error("ms_accum: FIX_W must be below ACC_W and at least 2");
   end

   ms_mode_e                 mode_q;
   logic [ACC_W-1:0]         dot_res;
   logic signed [FIX_W:0]    fsum;
   logic signed [FIX_W-1:0]  fsat;
   logic [ACC_W-1:0]         fix_res;

   always_comb begin
      dot_res = acc_in + sum_in;
      fsum    = {acc_in[FIX_W-1], acc_in[FIX_W-1:0]} + {sum_in[FIX_W-1], sum_in[FIX_W-1:0]};
      if (fsum[FIX_W] != fsum[FIX_W-1]) begin
         fsat = fsum[FIX_W] ? F_MIN : F_MAX;
      end else begin
         fsat = fsum[FIX_W-1:0];
      end
      fix_res = ACC_W'(fsat);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out  <= 1'b0;
         mode_q <= MODE_DOT;
         result <= '0;
      end else begin
         v_out <= v_in;
         if (v_in) begin
            mode_q <= mode_in;
            result <= (mode_in == MODE_FIX) ? fix_res : dot_res;
         end
      end
   end

   // R7
   fix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_out && mode_q == MODE_FIX)
      |-> ((&result[ACC_W-1:FIX_W-1]) || !(|result[ACC_W-1:FIX_W-1])));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !v_in |=> $stable(result));

endmodule

// File: rtl/mulsum_acc.sv
module mulsum_acc
   import mulsum_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 16,
   parameter int ACC_W  = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      in_mode,
   input  logic [LANES*LANE_W-1:0]   src_a,
   input  logic [LANES*LANE_W-1:0]   src_b,
   input  logic [ACC_W-1:0]          acc_in,
   output logic                      out_valid,
   output logic [ACC_W-1:0]          result
);
   localparam int PROD_W = 2 * LANE_W;
   localparam int GROW_W = $clog2(LANES);

   if (LANES < 1 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("mulsum_acc: LANES must be a power of two");
   end
   if (ACC_W < PROD_W + GROW_W + 1) begin : g_bad_acc
      $error("mulsum_acc: ACC_W too narrow for the lane products");
   end

   ms_mode_e                  mode_in_e;
   logic [LANES-1:0]          lane_en;
   logic [LANES*PROD_W-1:0]   prod_flat;

   logic                      v1;
   ms_mode_e                  mode1;
   logic [ACC_W-1:0]          acc1;

   logic                      v2;
   ms_mode_e                  mode2;
   logic [ACC_W-1:0]          acc2;
   logic [ACC_W-1:0]          sum2;

   assign mode_in_e = ms_mode_e'(in_mode);

   // Stage 1: per-lane multipliers; fixed mode only clocks lane 0
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_first
         assign lane_en[l] = in_valid;
      end else begin : g_rest
         assign lane_en[l] = in_valid && (mode_in_e == MODE_DOT);
      end

      ms_lane_mul #(.LANE_W(LANE_W)) u_mul (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (lane_en[l]),
         .a    (src_a[l*LANE_W +: LANE_W]),
         .b    (src_b[l*LANE_W +: LANE_W]),
         .prod (prod_flat[l*PROD_W +: PROD_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         mode1 <= MODE_DOT;
         acc1  <= '0;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            mode1 <= mode_in_e;
            acc1  <= acc_in;
         end
      end
   end

   // Stage 2: reduction tree or fixed-point scaling
   ms_reduce #(.LANES(LANES), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_reduce (
      .clk      (clk),
      .rst_n    (rst_n),
      .v_in     (v1),
      .mode_in  (mode1),
      .acc_in   (acc1),
      .prod_flat(prod_flat),
      .v_out    (v2),
      .mode_out (mode2),
      .acc_out  (acc2),
      .sum_out  (sum2)
   );

   // Stage 3: accumulate
   ms_accum #(.ACC_W(ACC_W), .FIX_W(PROD_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_in   (v2),
      .mode_in(mode2),
      .acc_in (acc2),
      .sum_in (sum2),
      .v_out  (out_valid),
      .result (result)
   );

   // R4
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 out_valid);

   // R9
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##3 !out_valid);

endmodule

// File: tb/tb_mulsum_acc.sv
`timescale 1ns/1ps
module tb_mulsum_acc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_mode = 1'b0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [63:0] acc_in = '0;
   logic        out_valid;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        hv [3];
   logic [63:0] he [3];
   string       ht [3];
   logic [63:0] last_res = '0;

   always #2.5 clk = ~clk;

   mulsum_acc dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
      .out_valid(out_valid), .result(result)
   );

   function automatic longint lane(input logic [63:0] w, input int l);
      return longint'($signed(w[l*16 +: 16]));
   endfunction

   function automatic logic [63:0] model(input logic m, input logic [63:0] a,
                                         input logic [63:0] b, input logic [63:0] c);
      logic [63:0] s;
      longint p, t;
      if (!m) begin
         s = c;
         for (int l = 0; l < 4; l++) s = s + 64'(lane(a, l) * lane(b, l));
         return s;
      end
      p = 2 * lane(a, 0) * lane(b, 0);
      if (p > 64'sd2147483647) p = 64'sd2147483647;
      if (p < -64'sd2147483648) p = -64'sd2147483648;
      t = longint'($signed(c[31:0])) + p;
      if (t > 64'sd2147483647) t = 64'sd2147483647;
      if (t < -64'sd2147483648) t = -64'sd2147483648;
      return 64'(t);
   endfunction

   task automatic step(input logic v, input logic m, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] c, input string tag);
      @(negedge clk);
      checks++;
      if (hv[2]) begin
         if (out_valid !== 1'b1 || result !== he[2]) begin
            errors++;
            $display("FAIL %s R4: out_valid=%b result=%h expected out_valid=1 result=%h",
                     ht[2], out_valid, result, he[2]);
         end
      end else begin
         if (out_valid !== 1'b0 || result !== last_res) begin
            errors++;
            $display("FAIL R9: out_valid=%b result=%h expected out_valid=0 result=%h",
                     out_valid, result, last_res);
         end
      end
      if (out_valid === 1'b1) last_res = result;
      hv[2] = hv[1]; he[2] = he[1]; ht[2] = ht[1];
      hv[1] = hv[0]; he[1] = he[0]; ht[1] = ht[0];
      in_valid = v; in_mode = m; src_a = a; src_b = b; acc_in = c;
      hv[0] = v; he[0] = model(m, a, b, c); ht[0] = tag;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic signed [15:0] cv [8];
      logic [63:0] ac [4];
      logic [63:0] a, b, c;
      cv[0] = -16'sd32768; cv[1] = -16'sd32767; cv[2] = -16'sd2; cv[3] = -16'sd1;
      cv[4] = 16'sd0;      cv[5] = 16'sd1;      cv[6] = 16'sd32766; cv[7] = 16'sd32767;
      ac[0] = 64'h0; ac[1] = 64'h7FFF_FFFF_FFFF_FFFF;
      ac[2] = 64'h8000_0000_0000_0000; ac[3] = 64'hFFFF_FFFF_FFFF_FFFF;
      for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; he[i] = '0; ht[i] = ""; end

      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== 64'h0) begin
         errors++;
         $display("FAIL R1: out_valid=%b result=%h expected out_valid=0 result=0", out_valid, result);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== 64'h0) begin
         errors++;
         $display("FAIL R1: out_valid=%b result=%h expected out_valid=0 result=0", out_valid, result);
      end

      // R3: full negative lanes wrap past the top of the range
      step(1, 0, {4{16'h8000}}, {4{16'h8000}}, 64'h7FFF_FFFF_FFFF_FFFF, "R3");
      checks++;
      if (model(0, {4{16'h8000}}, {4{16'h8000}}, 64'h7FFF_FFFF_FFFF_FFFF) !== 64'h8000_0000_FFFF_FFFF) begin
         errors++;
         $display("FAIL R3: model value does not match stated example");
      end
      step(1, 0, {4{16'h8000}}, {4{16'h7FFF}}, 64'h8000_0000_0000_0000, "R3");
      step(0, 0, '0, '0, '0, "R9");

      // R2, R5: back-to-back corner sweep in dot mode
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            a = {cv[i], cv[j], cv[(i+1)%8], cv[7-j]};
            b = {cv[j], cv[i], cv[7-i], cv[(j+3)%8]};
            step(1, 0, a, b, ac[(i+j)%4], "R2 R5");
         end
      end
      step(0, 0, '0, '0, '0, "R9");

      // R6, R7: fixed mode lane-0 corner sweep with accumulator corners
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            a = {rnd64() >> 16, cv[i]};
            b = {rnd64() >> 16, cv[j]};
            c = {$urandom, 32'h0};
            case ((i + j) % 4)
               0: c[31:0] = 32'h0;
               1: c[31:0] = 32'h7FFF_FFFF;
               2: c[31:0] = 32'h8000_0000;
               default: c[31:0] = 32'hFFFF_FFFF;
            endcase
            step(1, 1, a, b, c, "R6 R7");
         end
      end

      // R8: same lane 0, differing upper lanes, identical expected result
      for (int k = 0; k < 8; k++) begin
         a = {rnd64() >> 16, 16'h8000};
         b = {rnd64() >> 16, 16'h8000};
         step(1, 1, a, b, 64'h0000_0000_0000_0005, "R8");
      end

      // R4, R9, R5: random traffic with bubbles, both modes
      for (int k = 0; k < 600; k++) begin
         step(($urandom % 4) != 0, $urandom % 2, rnd64(), rnd64(), rnd64(), "R2 R7 R5");
      end

      // drain
      for (int k = 0; k < 4; k++) step(0, 0, '0, '0, '0, "R9");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule